// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a single-clock synchronous static RAM together with the access pipeline that lets a shared data bus carry a read or a write on every clock. The address, command, byte enables and write data all enter through registers on the rising edge. A write presents its data two enabled cycles after its address, which is the same slot in which a read returns its data. Because of this alignment, reads and writes can be mixed in any order on consecutive clocks without an idle cycle between them.

Each cycle either loads a new external address and command, or advances a small burst counter. When it advances, the previous command type continues at the next address of a linear or an interleaved burst. Three chip selects gate a loaded command. An active-low clock enable freezes the whole block. A read whose address matches a write that has not yet reached the array returns the pending write data, lane by lane. The tri-state data pad is split into separate in and out ports plus a drive-enable output.

Top module: `nws_sram`

## Requirements
- R1: A selected read accepted at enabled edge k shows its word on `dout` with `dout_oe` high after enabled edge k+2. The outputs hold that value until the next enabled edge.
- R2: A selected write accepted at enabled edge k takes its data from `din` at enabled edge k+2. A later read of that address returns it.
- R3: Reads, writes and deselects may follow one another on every enabled edge in any order. Each read returns the contents left by all earlier accepted writes.
- R4: `byte_we_n` is active low and is sampled with the address. Lane i covers bits 9i+8..9i. A write changes only the lanes whose bit is 0, and the other lanes keep their stored value.
- R5: While `clk_en_n` is 1, every input is ignored and all state holds. `dout` and `dout_oe` stay unchanged, and a command presented in that cycle is never executed.
- R6: With `adv_ld` = 0, a command is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. `rd_wr_n`=1 selects a read and 0 selects a write. Any other chip-select combination is a deselect that writes nothing and drives nothing.
- R7: With `adv_ld` = 1, the chip selects and `rd_wr_n` are ignored. The 2-bit burst count n is incremented mod 4, and the last loaded command repeats at the address whose low two bits are (base + n) mod 4 when `burst_order`=0. The upper bits come from the loaded address.
- R8: With `burst_order`=1, the low two bits of a burst address are base XOR n.
- R9: A read accepted one enabled edge after a write to the same address returns the written lanes from that write's data and the other lanes from the array.
- R10: `dout_oe` is 0 in every cycle that does not carry read data, including cycles after writes, deselects and empty bursts.
- R11: After reset, `dout_oe` is 0 and the last command is a deselect. Advance cycles issued before the first load do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| adv_ld | input | 1 | 0 loads a new address and command, 1 advances the burst |
| rd_wr_n | input | 1 | 1 read, 0 write, sampled on a load |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| byte_we_n | input | WORD_W/9 | Per-lane write enables, active low |
| burst_order | input | 1 | 0 linear burst, 1 interleaved burst |
| addr | input | $clog2(DEPTH) | Word address |
| din | input | WORD_W | Write data, two enabled cycles after the address |
| dout | output | WORD_W | Read data |
| dout_oe | output | 1 | High while `dout` carries read data |

## Verification
The case that needs the most care is a pending write committing to the array at the same edge at which a following read samples that address. In that case the array read and the lane forwarding happen together. The bench provokes this by issuing a write and then a read of the same address on the next edge, with random lane masks, and also a version with one idle cycle between them. It judges the result against a reference memory that the bench updates when each write is issued. Stalls from the clock enable are mixed into random streams of mixed commands, so that a freeze also lands on cycles where a forward or a burst step is in progress.

// File: rtl/nws_pkg.sv
package nws_pkg;
   localparam int LANE_W = 9;

   typedef enum logic [1:0] {
      CMD_IDLE = 2'd0,
      CMD_RD   = 2'd1,
      CMD_WR   = 2'd2
   } cmd_e;
endpackage

// File: rtl/nws_burst.sv
module nws_burst
   import nws_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BURST_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              adv_ld,
   input  logic              rd_wr_n,
   input  logic              sel_all,
   input  logic              interleave,
   input  logic [ADDR_W-1:0] addr_in,
   output cmd_e              cmd_now,
   output logic [ADDR_W-1:0] addr_now,
   output cmd_e              last_cmd
);
   localparam int BW = $clog2(BURST_LEN);

   if (BURST_LEN < 2 || (1 << BW) != BURST_LEN) begin : g_bad_len
      $error("BURST_LEN must be a power of two of at least 2");
   end
   if (ADDR_W <= BW) begin : g_bad_aw
      $error("address must be wider than the burst counter");
   end

   logic [ADDR_W-1:0] base_q;
   logic [BW-1:0]     cnt_q;
   logic [BW-1:0]     cnt_nx;
   logic [BW-1:0]     low_nx;
   cmd_e              last_q;

   // next burst position and its address offset
   always_comb begin
      cnt_nx = cnt_q + BW'(1);
      if (interleave) low_nx = base_q[BW-1:0] ^ cnt_nx;
      else            low_nx = base_q[BW-1:0] + cnt_nx;
   end

   always_comb begin
      if (!adv_ld) begin
         if (sel_all) cmd_now = rd_wr_n ? CMD_RD : CMD_WR;
         else         cmd_now = CMD_IDLE;
         addr_now = addr_in;
      end else begin
         cmd_now  = last_q;
         addr_now = {base_q[ADDR_W-1:BW], low_nx};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         last_q <= CMD_IDLE;
      end else if (en) begin
         if (!adv_ld) begin
            base_q <= addr_in;
            cnt_q  <= '0;
            last_q <= cmd_now;
         end else begin
            cnt_q <= cnt_nx;
         end
      end
   end

   assign last_cmd = last_q;
endmodule

// File: rtl/nws_pipe.sv
module nws_pipe
   import nws_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  cmd_e              cmd_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [LANES-1:0]  be_n_in,
   output cmd_e              s1_cmd,
   output logic [ADDR_W-1:0] s1_addr,
   output cmd_e              s2_cmd,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [LANES-1:0]  s2_be_n
);
   logic [LANES-1:0] s1_be_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_cmd  <= CMD_IDLE;
         s1_addr <= '0;
         s1_be_n <= '1;
         s2_cmd  <= CMD_IDLE;
         s2_addr <= '0;
         s2_be_n <= '1;
      end else if (en) begin
         s1_cmd  <= cmd_in;
         s1_addr <= addr_in;
         s1_be_n <= be_n_in;
         s2_cmd  <= s1_cmd;
         s2_addr <= s1_addr;
         s2_be_n <= s1_be_n;
      end
   end
endmodule

// File: rtl/nws_array.sv
module nws_array
   import nws_pkg::*;
#(
   parameter int WORD_W = 36,
   parameter int DEPTH  = 256
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [WORD_W/LANE_W-1:0]  wmask,
   input  logic [$clog2(DEPTH)-1:0]  waddr,
   input  logic [WORD_W-1:0]         wdata,
   input  logic                      re,
   input  logic [$clog2(DEPTH)-1:0]  raddr,
   output logic [WORD_W-1:0]         rdata
);
   localparam int LANES = WORD_W / LANE_W;

   logic [WORD_W-1:0] mem [DEPTH];

   // lane-masked write; a read at the same edge sees the old word
   always_ff @(posedge clk) begin
      if (we) begin
         for (int l = 0; l < LANES; l++) begin
            if (wmask[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
         end
      end
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/nws_rdout.sv
module nws_rdout
   import nws_pkg::*;
#(
   parameter int WORD_W = 36,
   parameter int ADDR_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  cmd_e                      s1_cmd,
   input  logic [ADDR_W-1:0]         s1_addr,
   input  cmd_e                      s2_cmd,
   input  logic [ADDR_W-1:0]         s2_addr,
   input  logic [WORD_W/LANE_W-1:0]  s2_be_n,
   input  logic [WORD_W-1:0]         din,
   input  logic [WORD_W-1:0]         rdata,
   output logic [WORD_W-1:0]         dout,
   output logic                      dout_oe
);
   localparam int LANES = WORD_W / LANE_W;

   logic [LANES-1:0]  fwd_mask_q;
   logic [WORD_W-1:0] fwd_data_q;
   logic [WORD_W-1:0] merged;
   logic              hit;

   // the write committing now collides with the read sampling the array now
   assign hit = (s1_cmd == CMD_RD) && (s2_cmd == CMD_WR) && (s1_addr == s2_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*LANE_W +: LANE_W] = fwd_mask_q[g] ? fwd_data_q[g*LANE_W +: LANE_W]
                                                        : rdata[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_mask_q <= '0;
         fwd_data_q <= '0;
         dout       <= '0;
         dout_oe    <= 1'b0;
      end else if (en) begin
         fwd_mask_q <= hit ? ~s2_be_n : '0;
         fwd_data_q <= din;
         if (s2_cmd == CMD_RD) dout <= merged;
         dout_oe <= (s2_cmd == CMD_RD);
      end
   end
endmodule

// File: rtl/nws_sram.sv
module nws_sram
   import nws_pkg::*;
#(
   parameter int WORD_W    = 36,
   parameter int DEPTH     = 256,
   parameter int BURST_LEN = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clk_en_n,
   input  logic                      adv_ld,
   input  logic                      rd_wr_n,
   input  logic                      sel_a_n,
   input  logic                      sel_b,
   input  logic                      sel_c_n,
   input  logic [WORD_W/9-1:0]       byte_we_n,
   input  logic                      burst_order,
   input  logic [$clog2(DEPTH)-1:0]  addr,
   input  logic [WORD_W-1:0]         din,
   output logic [WORD_W-1:0]         dout,
   output logic                      dout_oe
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int LANES  = WORD_W / LANE_W;

   if (WORD_W != 36 && WORD_W != 18) begin : g_bad_word
      $error("WORD_W must be 36 or 18");
   end
   if (DEPTH < 2*BURST_LEN || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two above the burst length");
   end

   logic              en;
   logic              sel_all;
   cmd_e              cmd_now;
   cmd_e              last_cmd;
   cmd_e              s1_cmd;
   cmd_e              s2_cmd;
   logic [ADDR_W-1:0] addr_now;
   logic [ADDR_W-1:0] s1_addr;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_be_n;
   logic [WORD_W-1:0] rdata;

   assign en      = !clk_en_n;
   assign sel_all = !sel_a_n && sel_b && !sel_c_n;

   nws_burst #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_burst (
      .clk(clk), .rst_n(rst_n), .en(en), .adv_ld(adv_ld), .rd_wr_n(rd_wr_n),
      .sel_all(sel_all), .interleave(burst_order), .addr_in(addr),
      .cmd_now(cmd_now), .addr_now(addr_now), .last_cmd(last_cmd)
   );

   nws_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
      .clk(clk), .rst_n(rst_n), .en(en), .cmd_in(cmd_now), .addr_in(addr_now),
      .be_n_in(byte_we_n), .s1_cmd(s1_cmd), .s1_addr(s1_addr),
      .s2_cmd(s2_cmd), .s2_addr(s2_addr), .s2_be_n(s2_be_n)
   );

   nws_array #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_array (
      .clk(clk), .we(en && (s2_cmd == CMD_WR)), .wmask(~s2_be_n), .waddr(s2_addr),
      .wdata(din), .re(en && (s1_cmd == CMD_RD)), .raddr(s1_addr), .rdata(rdata)
   );

   nws_rdout #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_rdout (
      .clk(clk), .rst_n(rst_n), .en(en), .s1_cmd(s1_cmd), .s1_addr(s1_addr),
      .s2_cmd(s2_cmd), .s2_addr(s2_addr), .s2_be_n(s2_be_n), .din(din),
      .rdata(rdata), .dout(dout), .dout_oe(dout_oe)
   );
endmodule

// File: rtl/nws_sram_chk.sv
module nws_sram_chk
   import nws_pkg::*;
#(
   parameter int WORD_W = 36
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en_n,
   input logic              adv_ld,
   input logic              rd_wr_n,
   input logic              sel_a_n,
   input logic              sel_b,
   input logic              sel_c_n,
   input cmd_e              s1_cmd,
   input cmd_e              s2_cmd,
   input cmd_e              last_cmd,
   input logic [WORD_W-1:0] dout,
   input logic              dout_oe
);
   logic chosen;
   assign chosen = !sel_a_n && sel_b && !sel_c_n;

   a_r5_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(dout) && $stable(dout_oe));

   a_r5_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> $stable(s1_cmd) && $stable(s2_cmd) && $stable(last_cmd));

   a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && s2_cmd == CMD_RD) |=> dout_oe);

   a_r10_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && s2_cmd != CMD_RD) |=> !dout_oe);

   a_r6_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv_ld && !chosen) |=> s1_cmd == CMD_IDLE);

   a_r6_load_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv_ld && chosen) |=> s1_cmd == ($past(rd_wr_n) ? CMD_RD : CMD_WR));

   a_r7_burst_repeats: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && adv_ld) |=> s1_cmd == $past(last_cmd));

   a_r3_pipe_moves: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en_n |=> s2_cmd == $past(s1_cmd));
endmodule

bind nws_sram nws_sram_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
   .rd_wr_n(rd_wr_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
   .s1_cmd(s1_cmd), .s2_cmd(s2_cmd), .last_cmd(last_cmd),
   .dout(dout), .dout_oe(dout_oe)
);

// File: tb/nws_sram_tb.sv
`timescale 1ns/1ps
module nws_sram_tb;
   localparam int W  = 36;
   localparam int D  = 256;
   localparam int L  = W / 9;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en_n = 1'b0;
   logic          adv_ld = 1'b0;
   logic          rd_wr_n = 1'b1;
   logic          sel_a_n = 1'b1;
   logic          sel_b = 1'b0;
   logic          sel_c_n = 1'b1;
   logic [L-1:0]  byte_we_n = '1;
   logic          burst_order = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  din = '0;
   logic [W-1:0]  dout;
   logic          dout_oe;

   always #2.5 clk = ~clk;

   nws_sram #(.WORD_W(W), .DEPTH(D), .BURST_LEN(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
      .rd_wr_n(rd_wr_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .byte_we_n(byte_we_n), .burst_order(burst_order), .addr(addr),
      .din(din), .dout(dout), .dout_oe(dout_oe)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   string cur_req = "R11";

   logic [W-1:0]  refm [D];
   logic [AW-1:0] b_base = '0;
   int            b_cnt  = 0;
   int            b_last = 0;      // 0 none, 1 read, 2 write
   logic [W-1:0]  dq1 = '0, dq2 = '0;
   bit            e1_rd = 0, e2_rd = 0;
   logic [W-1:0]  e1_v = '0, e2_v = '0;

   function automatic logic [W-1:0] pat(input int a, input int s);
      logic [23:0] lo;
      lo = 24'(a * 40503 + s * 977 + 24'h35A1C3);
      return {4'(s), 8'(a), lo};
   endfunction

   function automatic logic [W-1:0] mergew(input logic [W-1:0] old, input logic [W-1:0] nw,
                                           input logic [L-1:0] be_n);
      logic [W-1:0] r;
      r = old;
      for (int i = 0; i < L; i++) if (!be_n[i]) r[i*9 +: 9] = nw[i*9 +: 9];
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // one clock: stall, or an enabled cycle; sel = {sel_a_n, sel_b, sel_c_n}
   task automatic step(input bit stall, input bit adv, input bit rdwr, input logic [2:0] sel,
                       input logic [L-1:0] be_n, input logic [AW-1:0] a, input logic [W-1:0] wd);
      int            kind;
      logic [AW-1:0] eff;
      logic [1:0]    low;
      logic [W-1:0]  pd;
      bit            poe;
      @(negedge clk);
      {sel_a_n, sel_b, sel_c_n} = sel;
      adv_ld = adv; rd_wr_n = rdwr; byte_we_n = be_n; addr = a;
      if (stall) begin
         clk_en_n = 1'b1;
         din = wd;
         pd = dout; poe = dout_oe;
         @(posedge clk); #1;
         check(dout == pd && dout_oe == poe, "R5", {dout[W-2:0], dout_oe}, {pd[W-2:0], poe});
         return;
      end
      if (!adv) begin
         kind = (sel == 3'b010) ? (rdwr ? 1 : 2) : 0;
         b_base = a; b_cnt = 0; b_last = kind; eff = a;
      end else begin
         b_cnt = (b_cnt + 1) % 4;
         low = burst_order ? (b_base[1:0] ^ 2'(b_cnt)) : (b_base[1:0] + 2'(b_cnt));
         eff = {b_base[AW-1:2], low};
         kind = b_last;
      end
      if (kind == 2) refm[eff] = mergew(refm[eff], wd, be_n);
      clk_en_n = 1'b0;
      din = dq2;
      @(posedge clk); #1;
      if (e2_rd) check(dout_oe == 1'b1, "R1", W'(dout_oe), W'(1));
      else       check(dout_oe == 1'b0, "R10", W'(dout_oe), W'(0));
      if (e2_rd) check(dout == e2_v, cur_req, dout, e2_v);
      e2_rd = e1_rd; e2_v = e1_v;
      e1_rd = (kind == 1); e1_v = refm[eff];
      dq2 = dq1; dq1 = wd;
   endtask

   task automatic flush();
      for (int i = 0; i < 3; i++) step(0, 0, 1, 3'b111, '1, '0, '0);
   endtask

   task automatic burst_run(input logic [AW-1:0] base, input int seed);
      step(0, 0, 0, 3'b010, '0, base, pat(seed, 3));
      for (int n = 1; n < 6; n++) step(0, 1, 1, 3'b101, '0, ~base, pat(seed + n, 3));
      step(0, 0, 1, 3'b010, '1, base, '0);
      for (int n = 1; n < 6; n++) step(0, 1, 0, 3'b111, '0, ~base, '1);
      flush();
   endtask

   initial begin
      for (int i = 0; i < D; i++) refm[i] = 'x;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      cur_req = "R11";
      check(dout_oe == 1'b0, "R11", W'(dout_oe), W'(0));
      // advance before any load: nothing happens (R11)
      for (int i = 0; i < 3; i++) step(0, 1, 1, 3'b010, '0, 8'(i), '0);
      // R2: fill every word, then R1: read every word back to back
      cur_req = "R2";
      for (int a = 0; a < D; a++) step(0, 0, 0, 3'b010, '0, 8'(a), pat(a, 1));
      cur_req = "R1";
      for (int a = 0; a < D; a++) step(0, 0, 1, 3'b010, '0, 8'(a), '0);
      flush();
      // R4: every lane mask on partial writes
      cur_req = "R4";
      for (int a = 0; a < 64; a++) step(0, 0, 0, 3'b010, 4'(a), 8'(a), pat(a, 2));
      for (int a = 0; a < 64; a++) step(0, 0, 1, 3'b010, '0, 8'(a), '0);
      flush();
      // R9: read right behind a write to the same word, gap of 1 and 2
      cur_req = "R9";
      for (int i = 0; i < 32; i++) begin
         logic [AW-1:0] ra;
         ra = 8'($urandom);
         step(0, 0, 0, 3'b010, 4'($urandom), ra, pat(i, 4));
         step(0, 0, 1, 3'b010, '0, ra, '0);
         step(0, 0, 0, 3'b010, 4'($urandom), ra, pat(i, 5));
         step(0, 0, 1, 3'b011, '0, ra, '0);
         step(0, 0, 1, 3'b010, '0, ra, '0);
      end
      flush();
      // R6: all chip-select combinations for writes and reads
      cur_req = "R6";
      for (int s = 0; s < 8; s++) step(0, 0, 0, 3'(s), '0, 8'(100 + s), pat(s, 6));
      for (int s = 0; s < 8; s++) step(0, 0, 1, 3'(s), '0, 8'(100 + s), '0);
      for (int s = 0; s < 8; s++) step(0, 0, 1, 3'b010, '0, 8'(100 + s), '0);
      flush();
      // R7 linear and R8 interleaved bursts from every start offset, with wrap
      @(negedge clk); burst_order = 1'b0;
      cur_req = "R7";
      for (int lo = 0; lo < 4; lo++) burst_run(8'(8'hC4 | lo), 10 * lo);
      @(negedge clk); burst_order = 1'b1;
      cur_req = "R8";
      for (int lo = 0; lo < 4; lo++) burst_run(8'(8'hD8 | lo), 10 * lo + 50);
      // R3 mixed traffic with R5 stalls
      cur_req = "R3";
      for (int i = 0; i < 600; i++) begin
         int r;
         r = int'($urandom % 100);
         step(r < 20, (r % 7) == 0, $urandom % 2 == 0, (r % 9 == 0) ? 3'(r) : 3'b010,
              4'($urandom), 8'($urandom % 32), pat(i, 7));
      end
      flush();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule